// File: doc/BRIEF.md
# Bank-Switchable Dual-Port Memory with Mailboxes

This block is a dual-port word memory split into four equal banks. Each bank belongs to exactly one of two ports, the left or the right. A four-bit ownership input picks the owner of each bank, one bit per bank. A port reaches main memory only in the banks it currently owns. An access to a bank the port does not own is dropped, and a sticky error flag records it. Moving a bank to the other port is a change of one ownership bit. The other banks keep serving their owners without a break.

Beside main memory there is a shared 64-word mailbox area that both ports can always reach, whatever the bank ownership. A port enters it by pulling its mailbox select low. It then uses only the low six bits of its word address, and the upper address bits have no effect. Writing the top mailbox word (address 63) raises an interrupt flag toward the opposite port. That port lowers the flag by reading the same word. This gives the two sides a doorbell for passing messages.

Each port has:
- an active-low and an active-high chip select;
- a write strobe;
- an output enable;
- two active-low byte-lane enables;
- a bank number and a word address.

Read results come out one cycle after the request, qualified by a per-port valid strobe. This result stream has no ready input and no back-pressure: the consumer must take the word in the cycle its valid is high.

Top module: `bsw_dpmem`

## Requirements
- R1: A port selected (cs_n low, cs high) with we_n low, mb_n high and a bank it owns writes wdata into that bank at the word address. A later read by the owner (we_n high, oe_n low) returns the stored word.
- R2: A main-memory write to a bank the port does not own leaves memory unchanged. A main-memory read of such a bank returns zero.
- R3: A port's err output goes high one cycle after any selected main-memory access to a bank it does not own. It then stays high until reset. Mailbox accesses never set it.
- R4: ub_n low enables the upper byte, bits 15:8, and lb_n low enables the lower byte, bits 7:0. A write changes only the enabled bytes. A read returns zero in the disabled bytes.
- R5: With mb_n low, a port reads and writes the shared 64-word mailbox at addr[5:0] whatever its bank field and the bank ownership. The upper address bits are ignored, and main memory is not touched.
- R6: A mailbox write to address 63 by one port sets the other port's irq one cycle later. A mailbox read of address 63 by a port clears its own irq. When both happen in one cycle, the set wins.
- R7: When both ports write the same mailbox word in one cycle, each byte enabled by the left port takes the left data. Bytes enabled only by the right port take the right data.
- R8: A port with cs_n high or cs low has no effect. A selected port with we_n low writes and returns no read result, whatever oe_n is. A selected port with we_n high and oe_n high returns no read result.
- R9: rvalid is high exactly one cycle after an accepted read, with rdata holding the result. rdata is zero whenever rvalid is low. A mailbox read returns the word as it was before any write in the same cycle.
- R10: During and after reset, rvalid, irq and err of both ports are low.
- R11: Changing a bank's ownership bit moves that bank, with its contents intact, to the other port from the next access on. Banks whose bit is unchanged keep working in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_owner | input | 4 | Bank ownership, bit b: 0 = left owns bank b, 1 = right owns it |
| l_cs_n | input | 1 | Left chip select, active low |
| l_cs | input | 1 | Left chip select, active high |
| l_we_n | input | 1 | Left write strobe, low = write, high = read |
| l_oe_n | input | 1 | Left output enable, active low |
| l_ub_n | input | 1 | Left upper byte enable, active low |
| l_lb_n | input | 1 | Left lower byte enable, active low |
| l_mb_n | input | 1 | Left mailbox select, active low |
| l_bank | input | 2 | Left bank number |
| l_addr | input | ADDR_W | Left word address within a bank |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data |
| l_rvalid | output | 1 | Left read data valid |
| l_irq | output | 1 | Interrupt toward the left port |
| l_err | output | 1 | Left sticky ownership error |
| r_cs_n | input | 1 | Right chip select, active low |
| r_cs | input | 1 | Right chip select, active high |
| r_we_n | input | 1 | Right write strobe, low = write, high = read |
| r_oe_n | input | 1 | Right output enable, active low |
| r_ub_n | input | 1 | Right upper byte enable, active low |
| r_lb_n | input | 1 | Right lower byte enable, active low |
| r_mb_n | input | 1 | Right mailbox select, active low |
| r_bank | input | 2 | Right bank number |
| r_addr | input | ADDR_W | Right word address within a bank |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data |
| r_rvalid | output | 1 | Right read data valid |
| r_irq | output | 1 | Interrupt toward the right port |
| r_err | output | 1 | Right sticky ownership error |

## Verification
The assertions take for granted that reset is asserted from time zero and that all inputs hold known values. They also assume bank_owner is sampled in the same cycle as the request it governs. The stimulus changes every input only on the falling clock edge. It holds reset for several cycles before the first request. It reads a main or mailbox word only after writing it, so no result depends on uninitialised storage. Ownership is changed only on falling edges between requests. Each access then sees one stable owner, as the unowned-read and error properties assume.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int DATA_W    = 16;
  localparam int LANES     = DATA_W / 8;
  localparam int MBX_W     = 6;

  typedef struct packed {
    logic              sel;
    logic              wr;
    logic              rd;
    logic              mb;
    logic [BANK_W-1:0] bank;
    logic [LANES-1:0]  be;
  } port_req_t;

  function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] be);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < LANES; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction
endpackage

// File: rtl/bsw_port_decode.sv
module bsw_port_decode
  import bsw_pkg::*;
(
  input  logic              cs_n,
  input  logic              cs,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic              mb_n,
  input  logic [BANK_W-1:0] bank,
  output port_req_t         req
);
  logic selected;
  assign selected = !cs_n && cs;

  always_comb begin
    req.sel  = selected;
    req.wr   = selected && !we_n;
    req.rd   = selected && we_n && !oe_n;
    req.mb   = !mb_n;
    req.bank = bank;
    req.be   = {!ub_n, !lb_n};
  end
endmodule

// File: rtl/bsw_bank.sv
module bsw_bank
  import bsw_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [LANES-1:0]  be,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (we && be[i]) mem[addr][i*8 +: 8] <= wdata[i*8 +: 8];
    end
    rdata <= mem[addr];
  end
endmodule

// File: rtl/bsw_mailbox.sv
module bsw_mailbox
  import bsw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  port_req_t         l_req,
  input  logic [MBX_W-1:0]  l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  input  port_req_t         r_req,
  input  logic [MBX_W-1:0]  r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] l_q,
  output logic [DATA_W-1:0] r_q,
  output logic              l_irq,
  output logic              r_irq
);
  localparam int WORDS = 1 << MBX_W;
  localparam logic [MBX_W-1:0] DOORBELL = {MBX_W{1'b1}};

  logic [DATA_W-1:0] mem [WORDS];
  logic l_we, r_we, l_bell_rd, r_bell_rd;

  assign l_we      = l_req.wr && l_req.mb;
  assign r_we      = r_req.wr && r_req.mb;
  assign l_bell_rd = l_req.rd && l_req.mb && (l_addr == DOORBELL);
  assign r_bell_rd = r_req.rd && r_req.mb && (r_addr == DOORBELL);

  // right lanes first, left lanes last so the left port wins a shared lane
  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (r_we && r_req.be[i]) mem[r_addr][i*8 +: 8] <= r_wdata[i*8 +: 8];
      if (l_we && l_req.be[i]) mem[l_addr][i*8 +: 8] <= l_wdata[i*8 +: 8];
    end
    l_q <= mem[l_addr];
    r_q <= mem[r_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_irq <= 1'b0;
      r_irq <= 1'b0;
    end else begin
      if (r_we && r_addr == DOORBELL) l_irq <= 1'b1;
      else if (l_bell_rd)             l_irq <= 1'b0;
      if (l_we && l_addr == DOORBELL) r_irq <= 1'b1;
      else if (r_bell_rd)             r_irq <= 1'b0;
    end
  end
endmodule

// File: rtl/bsw_dpmem.sv
module bsw_dpmem
  import bsw_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] bank_owner,
  input  logic                 l_cs_n,
  input  logic                 l_cs,
  input  logic                 l_we_n,
  input  logic                 l_oe_n,
  input  logic                 l_ub_n,
  input  logic                 l_lb_n,
  input  logic                 l_mb_n,
  input  logic [BANK_W-1:0]    l_bank,
  input  logic [ADDR_W-1:0]    l_addr,
  input  logic [DATA_W-1:0]    l_wdata,
  output logic [DATA_W-1:0]    l_rdata,
  output logic                 l_rvalid,
  output logic                 l_irq,
  output logic                 l_err,
  input  logic                 r_cs_n,
  input  logic                 r_cs,
  input  logic                 r_we_n,
  input  logic                 r_oe_n,
  input  logic                 r_ub_n,
  input  logic                 r_lb_n,
  input  logic                 r_mb_n,
  input  logic [BANK_W-1:0]    r_bank,
  input  logic [ADDR_W-1:0]    r_addr,
  input  logic [DATA_W-1:0]    r_wdata,
  output logic [DATA_W-1:0]    r_rdata,
  output logic                 r_rvalid,
  output logic                 r_irq,
  output logic                 r_err
);
  localparam int PORTS = 2;

  logic [PORTS-1:0]  cs_n_a, cs_a, we_n_a, oe_n_a, ub_n_a, lb_n_a, mb_n_a;
  logic [BANK_W-1:0] bank_a  [PORTS];
  logic [ADDR_W-1:0] addr_a  [PORTS];
  logic [DATA_W-1:0] wdata_a [PORTS];
  logic [DATA_W-1:0] rdata_a [PORTS];
  logic [DATA_W-1:0] mbx_q   [PORTS];
  logic [DATA_W-1:0] bank_q  [NUM_BANKS];
  port_req_t         req     [PORTS];
  logic [PORTS-1:0]  owned, rvalid_q, err_q;

  assign cs_n_a = {r_cs_n, l_cs_n};
  assign cs_a   = {r_cs,   l_cs};
  assign we_n_a = {r_we_n, l_we_n};
  assign oe_n_a = {r_oe_n, l_oe_n};
  assign ub_n_a = {r_ub_n, l_ub_n};
  assign lb_n_a = {r_lb_n, l_lb_n};
  assign mb_n_a = {r_mb_n, l_mb_n};
  assign bank_a[0]  = l_bank;   assign bank_a[1]  = r_bank;
  assign addr_a[0]  = l_addr;   assign addr_a[1]  = r_addr;
  assign wdata_a[0] = l_wdata;  assign wdata_a[1] = r_wdata;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic              rd_mb_q, rd_ok_q;
    logic [BANK_W-1:0] rd_bank_q;
    logic [LANES-1:0]  rd_be_q;
    logic [DATA_W-1:0] src;

    bsw_port_decode u_dec (
      .cs_n(cs_n_a[p]), .cs(cs_a[p]), .we_n(we_n_a[p]), .oe_n(oe_n_a[p]),
      .ub_n(ub_n_a[p]), .lb_n(lb_n_a[p]), .mb_n(mb_n_a[p]),
      .bank(bank_a[p]), .req(req[p])
    );

    assign owned[p] = (bank_owner[req[p].bank] == 1'(p));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rvalid_q[p] <= 1'b0;
        err_q[p]    <= 1'b0;
        rd_mb_q     <= 1'b0;
        rd_ok_q     <= 1'b0;
        rd_bank_q   <= '0;
        rd_be_q     <= '0;
      end else begin
        rvalid_q[p] <= req[p].rd;
        if (req[p].sel && !req[p].mb && !owned[p]) err_q[p] <= 1'b1;
        if (req[p].rd) begin
          rd_mb_q   <= req[p].mb;
          rd_ok_q   <= owned[p];
          rd_bank_q <= req[p].bank;
          rd_be_q   <= req[p].be;
        end
      end
    end

    always_comb begin
      if (rd_mb_q)      src = mbx_q[p];
      else if (rd_ok_q) src = bank_q[rd_bank_q];
      else              src = '0;
      rdata_a[p] = rvalid_q[p] ? (src & lane_mask(rd_be_q)) : '0;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic own_sel, bank_we;
    assign own_sel = bank_owner[b];
    assign bank_we = req[own_sel].wr && !req[own_sel].mb &&
                     (req[own_sel].bank == BANK_W'(b));

    bsw_bank #(.AW(ADDR_W)) u_bank (
      .clk(clk), .we(bank_we), .be(req[own_sel].be),
      .addr(addr_a[own_sel]), .wdata(wdata_a[own_sel]), .rdata(bank_q[b])
    );
  end

  bsw_mailbox u_mbx (
    .clk(clk), .rst_n(rst_n),
    .l_req(req[0]), .l_addr(addr_a[0][MBX_W-1:0]), .l_wdata(wdata_a[0]),
    .r_req(req[1]), .r_addr(addr_a[1][MBX_W-1:0]), .r_wdata(wdata_a[1]),
    .l_q(mbx_q[0]), .r_q(mbx_q[1]), .l_irq(l_irq), .r_irq(r_irq)
  );

  assign l_rdata  = rdata_a[0];
  assign r_rdata  = rdata_a[1];
  assign l_rvalid = rvalid_q[0];
  assign r_rvalid = rvalid_q[1];
  assign l_err    = err_q[0];
  assign r_err    = err_q[1];
endmodule

// File: rtl/bsw_dpmem_chk.sv
module bsw_dpmem_chk
  import bsw_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_BANKS-1:0] bank_owner,
  input logic                 l_cs_n, l_cs, l_we_n, l_oe_n, l_ub_n, l_lb_n, l_mb_n,
  input logic [BANK_W-1:0]    l_bank,
  input logic [ADDR_W-1:0]    l_addr,
  input logic [DATA_W-1:0]    l_wdata,
  input logic [DATA_W-1:0]    l_rdata,
  input logic                 l_rvalid, l_irq, l_err,
  input logic                 r_cs_n, r_cs, r_we_n, r_oe_n, r_ub_n, r_lb_n, r_mb_n,
  input logic [BANK_W-1:0]    r_bank,
  input logic [ADDR_W-1:0]    r_addr,
  input logic [DATA_W-1:0]    r_wdata,
  input logic [DATA_W-1:0]    r_rdata,
  input logic                 r_rvalid, r_irq, r_err
);
  logic l_read, r_read, l_write, r_write;
  assign l_read  = !l_cs_n && l_cs && l_we_n && !l_oe_n;
  assign r_read  = !r_cs_n && r_cs && r_we_n && !r_oe_n;
  assign l_write = !l_cs_n && l_cs && !l_we_n;
  assign r_write = !r_cs_n && r_cs && !r_we_n;

  assert_l_rvalid_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    l_rvalid |-> $past(l_read));
  assert_r_rvalid_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    r_rvalid |-> $past(r_read));
  assert_l_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !l_rvalid |-> l_rdata == '0);
  assert_r_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !r_rvalid |-> r_rdata == '0);
  assert_l_unowned_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (l_read && l_mb_n && bank_owner[l_bank]) |=> l_rdata == '0);
  assert_r_unowned_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (r_read && r_mb_n && !bank_owner[r_bank]) |=> r_rdata == '0);
  assert_l_err_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_cs_n && l_cs && l_mb_n && bank_owner[l_bank]) |=> l_err);
  assert_r_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    r_err |=> r_err);
  assert_l_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    l_err |=> l_err);
  assert_l_irq_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (r_write && !r_mb_n && r_addr[MBX_W-1:0] == {MBX_W{1'b1}}) |=> l_irq);
  assert_r_irq_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (l_write && !l_mb_n && l_addr[MBX_W-1:0] == {MBX_W{1'b1}}) |=> r_irq);
  assert_reset_state_R10: assert property (@(posedge clk)
    !rst_n |=> (!l_rvalid && !r_rvalid && !l_irq && !r_irq && !l_err && !r_err));
endmodule

bind bsw_dpmem bsw_dpmem_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/bsw_dpmem_tb_top.sv
module bsw_dpmem_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] owner = 4'b0000;
  logic cs_n [2], cs [2], we_n [2], oe_n [2], ub_n [2], lb_n [2], mb_n [2];
  logic [1:0]  bank  [2];
  logic [7:0]  addr  [2];
  logic [15:0] wdata [2];
  logic [15:0] l_rdata, r_rdata;
  logic l_rvalid, r_rvalid, l_irq, r_irq, l_err, r_err;

  always #10 clk = ~clk;

  bsw_dpmem #(.ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bank_owner(owner),
    .l_cs_n(cs_n[0]), .l_cs(cs[0]), .l_we_n(we_n[0]), .l_oe_n(oe_n[0]),
    .l_ub_n(ub_n[0]), .l_lb_n(lb_n[0]), .l_mb_n(mb_n[0]), .l_bank(bank[0]),
    .l_addr(addr[0]), .l_wdata(wdata[0]), .l_rdata(l_rdata), .l_rvalid(l_rvalid),
    .l_irq(l_irq), .l_err(l_err),
    .r_cs_n(cs_n[1]), .r_cs(cs[1]), .r_we_n(we_n[1]), .r_oe_n(oe_n[1]),
    .r_ub_n(ub_n[1]), .r_lb_n(lb_n[1]), .r_mb_n(mb_n[1]), .r_bank(bank[1]),
    .r_addr(addr[1]), .r_wdata(wdata[1]), .r_rdata(r_rdata), .r_rvalid(r_rvalid),
    .r_irq(r_irq), .r_err(r_err)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] mem_m [4][256];
  logic [15:0] mb_m  [64];
  bit exp_err [2], exp_irq [2], set_i [2], clr_i [2];
  bit pw [2], pmb [2];
  logic [1:0]  pbk [2];
  logic [7:0]  pad [2];
  logic [15:0] pd [2], pmask [2];
  logic [15:0] q_d0 [$], q_d1 [$];
  int          q_t0 [$], q_t1 [$];

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mask_of(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic idle(input int p);
    cs_n[p] = 1'b1; cs[p] = 1'b0; we_n[p] = 1'b1; oe_n[p] = 1'b1;
    ub_n[p] = 1'b1; lb_n[p] = 1'b1; mb_n[p] = 1'b1;
  endtask

  // mode: 0 selected, 1 cs_n held high, 2 cs held low
  task automatic drive(input int p, input int mode, input bit wr, input bit oe, input bit mb,
                       input logic [1:0] bk, input logic [7:0] ad, input logic [15:0] d,
                       input logic [1:0] be, input int tag);
    bit owned;
    logic [15:0] e;
    cs_n[p] = (mode == 1); cs[p] = (mode != 2); we_n[p] = !wr; oe_n[p] = !oe;
    ub_n[p] = !be[1]; lb_n[p] = !be[0]; mb_n[p] = !mb;
    bank[p] = bk; addr[p] = ad; wdata[p] = d;
    if (mode == 0) begin
      owned = (owner[bk] == (p == 1));
      if (!mb && !owned) exp_err[p] = 1;
      if (wr) begin
        if (mb || owned) begin
          pw[p] = 1; pmb[p] = mb; pbk[p] = bk; pad[p] = ad; pd[p] = d; pmask[p] = mask_of(be);
        end
        if (mb && ad[5:0] == 6'd63) set_i[1-p] = 1;
      end else if (oe) begin
        if (mb)         e = mb_m[ad[5:0]] & mask_of(be);
        else if (owned) e = mem_m[bk][ad] & mask_of(be);
        else            e = 16'h0000;
        if (p == 0) begin q_d0.push_back(e); q_t0.push_back(tag); end
        else        begin q_d1.push_back(e); q_t1.push_back(tag); end
        if (mb && ad[5:0] == 6'd63) clr_i[p] = 1;
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    for (int p = 1; p >= 0; p--) begin
      if (pw[p]) begin
        if (pmb[p]) mb_m[pad[p][5:0]] = (mb_m[pad[p][5:0]] & ~pmask[p]) | (pd[p] & pmask[p]);
        else mem_m[pbk[p]][pad[p]] = (mem_m[pbk[p]][pad[p]] & ~pmask[p]) | (pd[p] & pmask[p]);
      end
      pw[p] = 0;
    end
    for (int p = 0; p < 2; p++) begin
      if (set_i[p]) exp_irq[p] = 1;
      else if (clr_i[p]) exp_irq[p] = 0;
      set_i[p] = 0; clr_i[p] = 0;
    end
    @(negedge clk);
    idle(0); idle(1);
    check("R3 l_err", {15'd0, l_err}, {15'd0, exp_err[0]});
    check("R3 r_err", {15'd0, r_err}, {15'd0, exp_err[1]});
    check("R6 l_irq", {15'd0, l_irq}, {15'd0, exp_irq[0]});
    check("R6 r_irq", {15'd0, r_irq}, {15'd0, exp_irq[1]});
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && l_rvalid) begin
      if (q_d0.size() == 0) check("R9 left unexpected rvalid", 16'd1, 16'd0);
      else check($sformatf("R%0d left read", q_t0[0]), l_rdata, q_d0[0]);
      if (q_d0.size() != 0) begin void'(q_d0.pop_front()); void'(q_t0.pop_front()); end
    end
    if (rst_n && r_rvalid) begin
      if (q_d1.size() == 0) check("R9 right unexpected rvalid", 16'd1, 16'd0);
      else check($sformatf("R%0d right read", q_t1[0]), r_rdata, q_d1[0]);
      if (q_d1.size() != 0) begin void'(q_d1.pop_front()); void'(q_t1.pop_front()); end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(0); idle(1);
    for (int p = 0; p < 2; p++) begin
      bank[p] = 0; addr[p] = 0; wdata[p] = 0;
      exp_err[p] = 0; exp_irq[p] = 0; set_i[p] = 0; clr_i[p] = 0; pw[p] = 0;
    end
    repeat (4) @(negedge clk);
    // R10: outputs low while reset is held
    check("R10 l_rvalid", {15'd0, l_rvalid}, 16'd0);
    check("R10 r_rvalid", {15'd0, r_rvalid}, 16'd0);
    check("R10 irq", {14'd0, l_irq, r_irq}, 16'd0);
    check("R10 err", {14'd0, l_err, r_err}, 16'd0);
    rst_n = 1'b1;
    owner = 4'b1010;
    @(negedge clk);

    // R1: owners write their banks, then read back
    drive(0, 0, 1, 0, 0, 2'd0, 8'd5,   16'hA5A5, 2'b11, 1);
    drive(1, 0, 1, 0, 0, 2'd1, 8'd0,   16'hBEEF, 2'b11, 1);
    step();
    drive(0, 0, 1, 0, 0, 2'd2, 8'd255, 16'h1234, 2'b11, 1);
    drive(1, 0, 1, 0, 0, 2'd3, 8'd128, 16'h0F0F, 2'b11, 1);
    step();
    drive(0, 0, 0, 1, 0, 2'd0, 8'd5,   16'h0, 2'b11, 1);
    drive(1, 0, 0, 1, 0, 2'd1, 8'd0,   16'h0, 2'b11, 1);
    step();
    drive(0, 0, 0, 1, 0, 2'd2, 8'd255, 16'h0, 2'b11, 1);
    drive(1, 0, 0, 1, 0, 2'd3, 8'd128, 16'h0, 2'b11, 1);
    step();

    // R4: upper-lane write, then full and lower-lane reads
    drive(0, 0, 1, 0, 0, 2'd0, 8'd5, 16'h77FF, 2'b10, 4);
    step();
    drive(0, 0, 0, 1, 0, 2'd0, 8'd5, 16'h0, 2'b11, 4);
    step();
    drive(0, 0, 0, 1, 0, 2'd0, 8'd5, 16'h0, 2'b01, 4);
    step();
    drive(1, 0, 0, 1, 0, 2'd3, 8'd128, 16'h0, 2'b10, 4);
    step();

    // R8: deselected port, write with output enable, read without it
    drive(0, 1, 1, 0, 0, 2'd2, 8'd255, 16'hFFFF, 2'b11, 8);
    step();
    drive(0, 2, 1, 0, 0, 2'd2, 8'd255, 16'hEEEE, 2'b11, 8);
    step();
    drive(0, 0, 0, 0, 0, 2'd2, 8'd255, 16'h0, 2'b11, 8);
    step();
    drive(0, 0, 1, 1, 0, 2'd2, 8'd254, 16'h4321, 2'b11, 8);
    step();
    drive(0, 0, 0, 1, 0, 2'd2, 8'd255, 16'h0, 2'b11, 8);
    step();
    drive(0, 0, 0, 1, 0, 2'd2, 8'd254, 16'h0, 2'b11, 8);
    step();

    // R5: mailbox, upper address bits ignored, bank field ignored, no error
    drive(0, 0, 1, 0, 1, 2'd1, 8'hC3, 16'h1111, 2'b11, 5);
    step();
    drive(1, 0, 0, 1, 1, 2'd0, 8'h03, 16'h0, 2'b11, 5);
    drive(0, 0, 0, 1, 1, 2'd3, 8'h43, 16'h0, 2'b11, 5);
    step();
    drive(0, 0, 0, 1, 0, 2'd2, 8'hC3 & 8'hFF, 16'h0, 2'b11, 5); // bank2 owned by left, word C3 unwritten? read 255 instead
    q_d0.delete(q_d0.size()-1); q_t0.delete(q_t0.size()-1);
    idle(0);
    drive(0, 0, 0, 1, 0, 2'd2, 8'd255, 16'h0, 2'b11, 5);
    step();

    // R6: doorbell set by the right port, cleared by the left port's read
    drive(1, 0, 1, 0, 1, 2'd0, 8'h3F, 16'h9001, 2'b11, 6);
    step();
    drive(0, 0, 0, 1, 1, 2'd0, 8'hFF, 16'h0, 2'b11, 6);
    step();
    drive(0, 0, 1, 0, 1, 2'd0, 8'h3F, 16'h9002, 2'b11, 6);
    step();
    drive(1, 0, 0, 1, 1, 2'd0, 8'h3F, 16'h0, 2'b11, 6);
    step();
    // R6/R9: set and clear in one cycle, set wins; read sees the old word
    drive(1, 0, 1, 0, 1, 2'd0, 8'h3F, 16'h9003, 2'b11, 9);
    drive(0, 0, 0, 1, 1, 2'd0, 8'h3F, 16'h0, 2'b11, 9);
    step();
    drive(0, 0, 0, 1, 1, 2'd0, 8'h3F, 16'h0, 2'b11, 6);
    step();

    // R7: same-cycle mailbox write collisions
    drive(0, 0, 1, 0, 1, 2'd0, 8'd10, 16'hAAAA, 2'b11, 7);
    drive(1, 0, 1, 0, 1, 2'd0, 8'd10, 16'h5555, 2'b11, 7);
    step();
    drive(0, 0, 1, 0, 1, 2'd0, 8'd11, 16'h11FF, 2'b10, 7);
    drive(1, 0, 1, 0, 1, 2'd0, 8'd11, 16'h3344, 2'b11, 7);
    step();
    drive(1, 0, 0, 1, 1, 2'd0, 8'd10, 16'h0, 2'b11, 7);
    drive(0, 0, 0, 1, 1, 2'd0, 8'd11, 16'h0, 2'b11, 7);
    step();

    // R2/R3: right touches left-owned bank 0
    drive(1, 0, 1, 0, 0, 2'd0, 8'd5, 16'hDEAD, 2'b11, 2);
    step();
    drive(1, 0, 0, 1, 0, 2'd0, 8'd5, 16'h0, 2'b11, 2);
    drive(0, 0, 0, 1, 0, 2'd0, 8'd5, 16'h0, 2'b11, 2);
    step();

    // R11: move bank 0 to the right; bank 2 keeps serving the left
    owner = 4'b1011;
    drive(1, 0, 0, 1, 0, 2'd0, 8'd5,   16'h0, 2'b11, 11);
    drive(0, 0, 0, 1, 0, 2'd2, 8'd255, 16'h0, 2'b11, 11);
    step();
    drive(0, 0, 0, 1, 0, 2'd0, 8'd5, 16'h0, 2'b11, 2);
    step();
    drive(1, 0, 1, 0, 0, 2'd0, 8'd6, 16'hC0DE, 2'b11, 11);
    step();
    drive(1, 0, 0, 1, 0, 2'd0, 8'd6, 16'h0, 2'b11, 11);
    step();
    step();

    check("R9 left results outstanding",  16'(q_d0.size()), 16'd0);
    check("R9 right results outstanding", 16'(q_d1.size()), 16'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule